// File: doc/BRIEF.md
# SCSI Bus Drive Control Registers

This block holds the control registers that decide what a parallel SCSI bus controller drives onto the bus. A byte-wide processor port writes and reads five locations. These are an output data byte, an initiator command byte, a mode byte, a target command byte and a status byte. From their contents and from the sensed bus lines, the block produces a separate output-enable for every SCSI control line, for each data line and for the parity line. It also produces the pin value for each data line. A testbench or pad ring can therefore resolve the wired-OR bus itself. All bus pins are active-low. Control lines only ever pull low when enabled.

The mode byte selects the role. In the initiator role only ATN and ACK may be driven. In the target role only C/D, I/O, MSG and REQ may be driven. SEL and BSY follow their command bits in either role. The data byte goes onto the bus with a generated odd-parity bit when the assert-data bit is set. In the initiator role, data drive also needs the received I/O line to be false and the received phase lines to equal the expected phase held in the target command byte. This test is combinational, so a phase change drops the drive in the same cycle. An open-drain bit lets the data lines only pull low, as arbitration and selection require. When parity checking is enabled, a strobe marks a received byte and a parity error on it sets a sticky flag. A read of the status location clears that flag.

Top module: `scsi_drive_ctl`

## Requirements
- R1: While reset is held and right after it, every output-enable is 0, every readable location returns 0x00, and read data is 0x00 when no read is strobed.
- R2: A write to location 0 (data), 1 (initiator command), 2 (mode) or 3 (target command) takes effect at the next clock edge. A read returns the last written byte whatever the bus lines are doing.
- R3: atn_oe follows initiator-command bit 1 and ack_oe follows bit 4, but only while mode bit 6 (target role) is 0.
- R4: io_oe, cd_oe, msg_oe and req_oe follow target-command bits 0, 1, 2 and 3, but only while mode bit 6 is 1.
- R5: sel_oe follows initiator-command bit 2 and bsy_oe follows bit 3 in either role. A single write of 0x06 enables ATN and SEL together.
- R6: With initiator-command bit 0 set in the target role, all eight data enables and the parity enable are 1. db_n_o is the inverse of the data byte. dbp_n_o is 0 exactly when the data byte holds an even number of ones (odd parity over nine bits).
- R7: In the initiator role, data drive with bit 0 set needs all of these: bus_io_n_i = 1, and the received C/D, I/O and MSG (true when the pin is 0) equal target-command bits 1, 0 and 2. A mismatch removes the drive in the same cycle, without a clock edge.
- R8: While mode bit 7 (open drain) is set, a data or parity line is enabled only where its pin value is 0. With the bit clear, all lines are enabled together.
- R9: With mode bit 5 set, a cycle with rx_strobe_i high in which the nine received bits (true when the pin is 0) hold an even number of ones sets the parity-error flag, read as bit 0 of location 4. With bit 5 clear, such a byte is ignored. A byte with correct parity never sets the flag.
- R10: The parity-error flag stays set until location 4 is read. That read returns 1 and clears the flag. If a new error arrives in the same cycle as the clearing read, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | Register access strobe |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 3 | Register location |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational |
| bus_db_n_i | input | 8 | Sensed data pins (active-low) |
| bus_dbp_n_i | input | 1 | Sensed parity pin (active-low) |
| bus_cd_n_i | input | 1 | Sensed C/D pin (active-low) |
| bus_io_n_i | input | 1 | Sensed I/O pin (active-low) |
| bus_msg_n_i | input | 1 | Sensed MSG pin (active-low) |
| rx_strobe_i | input | 1 | Received byte valid for parity check |
| db_n_o | output | 8 | Data pin values |
| db_oe_o | output | 8 | Data pin enables |
| dbp_n_o | output | 1 | Parity pin value |
| dbp_oe_o | output | 1 | Parity pin enable |
| atn_oe_o | output | 1 | Pull ATN low |
| ack_oe_o | output | 1 | Pull ACK low |
| sel_oe_o | output | 1 | Pull SEL low |
| bsy_oe_o | output | 1 | Pull BSY low |
| cd_oe_o | output | 1 | Pull C/D low |
| io_oe_o | output | 1 | Pull I/O low |
| msg_oe_o | output | 1 | Pull MSG low |
| req_oe_o | output | 1 | Pull REQ low |

## Verification
Two functions can meet in one cycle. The parity check may set the error flag in the same cycle that a status read clears it. The bench provokes this by raising rx_strobe_i with a bad-parity byte in the very cycle it reads location 4. That read must return 0, and the next read must return 1, so the new error outranks the clear. A second overlap is a phase change on the sensed lines in the middle of a cycle in which data is being driven. The bench flips MSG between clock edges and requires the data enables to fall before the next edge.

// File: rtl/scsi_drive_pkg.sv
package scsi_drive_pkg;

   // mode byte bit positions (software decodes these)
   localparam int MODE_OD  = 7;
   localparam int MODE_TGT = 6;
   localparam int MODE_EPC = 5;

   // initiator command byte
   localparam int ICMD_ADB = 0;
   localparam int ICMD_ATN = 1;
   localparam int ICMD_SEL = 2;
   localparam int ICMD_BSY = 3;
   localparam int ICMD_ACK = 4;

   // target command byte (expected phase + REQ)
   localparam int TCMD_IO  = 0;
   localparam int TCMD_CD  = 1;
   localparam int TCMD_MSG = 2;
   localparam int TCMD_REQ = 3;

   // register slots; slot index equals location
   localparam int SLOT_ODATA = 0;
   localparam int SLOT_ICMD  = 1;
   localparam int SLOT_MODE  = 2;
   localparam int SLOT_TCMD  = 3;
   localparam int NUM_SLOTS  = 4;

   typedef enum logic [2:0] {
      LOC_ODATA = 3'd0,
      LOC_ICMD  = 3'd1,
      LOC_MODE  = 3'd2,
      LOC_TCMD  = 3'd3,
      LOC_STAT  = 3'd4
   } reg_loc_e;

   typedef struct packed {
      logic od;
      logic tgt;
      logic epc;
      logic adb;
      logic atn;
      logic sel;
      logic bsy;
      logic ack;
      logic x_io;
      logic x_cd;
      logic x_msg;
      logic x_req;
   } drive_ctl_t;

endpackage

// File: rtl/scsi_drive_regs.sv
module scsi_drive_regs
   import scsi_drive_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_sel,
   input  logic              cpu_wr,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              perr,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic [DATA_W-1:0] odata,
   output drive_ctl_t        ctl,
   output logic              stat_rd
);

   localparam logic [ADDR_W-1:0] STAT_LOC = ADDR_W'(LOC_STAT);

   logic [DATA_W-1:0]    bank_q [NUM_SLOTS];
   logic [NUM_SLOTS-1:0] wr_hit;
   logic                 rd_act;

   assign rd_act  = cpu_sel && !cpu_wr;
   assign stat_rd = rd_act && (cpu_addr == STAT_LOC);

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_dec
      assign wr_hit[g] = cpu_sel && cpu_wr && (cpu_addr == ADDR_W'(g));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_SLOTS; i++) bank_q[i] <= '0;
      end else begin
         for (int i = 0; i < NUM_SLOTS; i++)
            if (wr_hit[i]) bank_q[i] <= cpu_wdata;
      end
   end

   always_comb begin
      cpu_rdata = '0;
      if (rd_act) begin
         for (int i = 0; i < NUM_SLOTS; i++)
            if (cpu_addr == ADDR_W'(i)) cpu_rdata = bank_q[i];
         if (stat_rd) cpu_rdata = DATA_W'(perr);
      end
   end

   assign odata     = bank_q[SLOT_ODATA];
   assign ctl.od    = bank_q[SLOT_MODE][MODE_OD];
   assign ctl.tgt   = bank_q[SLOT_MODE][MODE_TGT];
   assign ctl.epc   = bank_q[SLOT_MODE][MODE_EPC];
   assign ctl.adb   = bank_q[SLOT_ICMD][ICMD_ADB];
   assign ctl.atn   = bank_q[SLOT_ICMD][ICMD_ATN];
   assign ctl.sel   = bank_q[SLOT_ICMD][ICMD_SEL];
   assign ctl.bsy   = bank_q[SLOT_ICMD][ICMD_BSY];
   assign ctl.ack   = bank_q[SLOT_ICMD][ICMD_ACK];
   assign ctl.x_io  = bank_q[SLOT_TCMD][TCMD_IO];
   assign ctl.x_cd  = bank_q[SLOT_TCMD][TCMD_CD];
   assign ctl.x_msg = bank_q[SLOT_TCMD][TCMD_MSG];
   assign ctl.x_req = bank_q[SLOT_TCMD][TCMD_REQ];

endmodule

// File: rtl/scsi_drive_parity.sv
module scsi_drive_parity #(
   parameter int DATA_W     = 8,
   parameter bit ODD_PARITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] odata,
   input  logic [DATA_W-1:0] bus_db_n,
   input  logic              bus_dbp_n,
   input  logic              rx_strobe,
   input  logic              epc,
   input  logic              stat_rd,
   output logic              par_bit,
   output logic              perr
);

   logic [DATA_W:0] rx_word;
   logic            rx_bad;
   logic            perr_q;

   assign rx_word = {~bus_dbp_n, ~bus_db_n};

   if (ODD_PARITY) begin : g_odd
      assign par_bit = ~^odata;
      assign rx_bad  = ~^rx_word;
   end else begin : g_even
      assign par_bit = ^odata;
      assign rx_bad  = ^rx_word;
   end

   // a fresh error wins over the clearing status read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          perr_q <= 1'b0;
      else if (rx_strobe && epc && rx_bad) perr_q <= 1'b1;
      else if (stat_rd)                    perr_q <= 1'b0;
   end

   assign perr = perr_q;

endmodule

// File: rtl/scsi_drive_gate.sv
module scsi_drive_gate #(
   parameter int DATA_W        = 8,
   parameter bit OPEN_DRAIN_EN = 1'b1
) (
   input  logic              od,
   input  logic              tgt,
   input  logic              adb,
   input  logic              atn,
   input  logic              sel,
   input  logic              bsy,
   input  logic              ack,
   input  logic              x_io,
   input  logic              x_cd,
   input  logic              x_msg,
   input  logic              x_req,
   input  logic [DATA_W-1:0] odata,
   input  logic              par_bit,
   input  logic              bus_cd_n,
   input  logic              bus_io_n,
   input  logic              bus_msg_n,
   output logic [DATA_W-1:0] db_n,
   output logic [DATA_W-1:0] db_oe,
   output logic              dbp_n,
   output logic              dbp_oe,
   output logic              atn_oe,
   output logic              ack_oe,
   output logic              sel_oe,
   output logic              bsy_oe,
   output logic              cd_oe,
   output logic              io_oe,
   output logic              msg_oe,
   output logic              req_oe
);

   logic phase_ok;
   logic data_en;

   assign phase_ok = ((~bus_cd_n)  == x_cd) &&
                     ((~bus_io_n)  == x_io) &&
                     ((~bus_msg_n) == x_msg);

   // target drives freely; initiator only while bus I/O is false and phase matches
   assign data_en = adb && (tgt || (bus_io_n && phase_ok));

   assign atn_oe = atn && !tgt;
   assign ack_oe = ack && !tgt;
   assign sel_oe = sel;
   assign bsy_oe = bsy;
   assign cd_oe  = x_cd  && tgt;
   assign io_oe  = x_io  && tgt;
   assign msg_oe = x_msg && tgt;
   assign req_oe = x_req && tgt;

   logic [DATA_W:0] line_val;
   logic [DATA_W:0] line_oe;

   assign line_val = {par_bit, odata};

   for (genvar i = 0; i <= DATA_W; i++) begin : g_line
      if (OPEN_DRAIN_EN) begin : g_od
         // open drain: release any line whose pin would go high
         assign line_oe[i] = data_en && (!od || line_val[i]);
      end else begin : g_pp
         assign line_oe[i] = data_en;
      end
   end

   assign db_n   = ~line_val[DATA_W-1:0];
   assign dbp_n  = ~line_val[DATA_W];
   assign db_oe  = line_oe[DATA_W-1:0];
   assign dbp_oe = line_oe[DATA_W];

endmodule

// File: rtl/scsi_drive_ctl.sv
module scsi_drive_ctl
   import scsi_drive_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int ADDR_W        = 3,
   parameter bit ODD_PARITY    = 1'b1,
   parameter bit OPEN_DRAIN_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_sel,
   input  logic              cpu_wr,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic [DATA_W-1:0] bus_db_n_i,
   input  logic              bus_dbp_n_i,
   input  logic              bus_cd_n_i,
   input  logic              bus_io_n_i,
   input  logic              bus_msg_n_i,
   input  logic              rx_strobe_i,
   output logic [DATA_W-1:0] db_n_o,
   output logic [DATA_W-1:0] db_oe_o,
   output logic              dbp_n_o,
   output logic              dbp_oe_o,
   output logic              atn_oe_o,
   output logic              ack_oe_o,
   output logic              sel_oe_o,
   output logic              bsy_oe_o,
   output logic              cd_oe_o,
   output logic              io_oe_o,
   output logic              msg_oe_o,
   output logic              req_oe_o
);

   if (DATA_W < 8) begin : g_bad_width
      $error("scsi_drive_ctl: DATA_W must be at least 8 to hold the control bits");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("scsi_drive_ctl: ADDR_W must be at least 3 to reach the status location");
   end

   drive_ctl_t        ctl;
   logic [DATA_W-1:0] odata;
   logic              stat_rd;
   logic              perr;
   logic              par_bit;

   scsi_drive_regs #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_sel   (cpu_sel),
      .cpu_wr    (cpu_wr),
      .cpu_addr  (cpu_addr),
      .cpu_wdata (cpu_wdata),
      .perr      (perr),
      .cpu_rdata (cpu_rdata),
      .odata     (odata),
      .ctl       (ctl),
      .stat_rd   (stat_rd)
   );

   scsi_drive_parity #(
      .DATA_W     (DATA_W),
      .ODD_PARITY (ODD_PARITY)
   ) i_parity (
      .clk       (clk),
      .rst_n     (rst_n),
      .odata     (odata),
      .bus_db_n  (bus_db_n_i),
      .bus_dbp_n (bus_dbp_n_i),
      .rx_strobe (rx_strobe_i),
      .epc       (ctl.epc),
      .stat_rd   (stat_rd),
      .par_bit   (par_bit),
      .perr      (perr)
   );

   scsi_drive_gate #(
      .DATA_W        (DATA_W),
      .OPEN_DRAIN_EN (OPEN_DRAIN_EN)
   ) i_gate (
      .od        (ctl.od),
      .tgt       (ctl.tgt),
      .adb       (ctl.adb),
      .atn       (ctl.atn),
      .sel       (ctl.sel),
      .bsy       (ctl.bsy),
      .ack       (ctl.ack),
      .x_io      (ctl.x_io),
      .x_cd      (ctl.x_cd),
      .x_msg     (ctl.x_msg),
      .x_req     (ctl.x_req),
      .odata     (odata),
      .par_bit   (par_bit),
      .bus_cd_n  (bus_cd_n_i),
      .bus_io_n  (bus_io_n_i),
      .bus_msg_n (bus_msg_n_i),
      .db_n      (db_n_o),
      .db_oe     (db_oe_o),
      .dbp_n     (dbp_n_o),
      .dbp_oe    (dbp_oe_o),
      .atn_oe    (atn_oe_o),
      .ack_oe    (ack_oe_o),
      .sel_oe    (sel_oe_o),
      .bsy_oe    (bsy_oe_o),
      .cd_oe     (cd_oe_o),
      .io_oe     (io_oe_o),
      .msg_oe    (msg_oe_o),
      .req_oe    (req_oe_o)
   );

endmodule

// File: rtl/scsi_drive_chk.sv
module scsi_drive_chk
   import scsi_drive_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_sel,
   input logic              cpu_wr,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [DATA_W-1:0] cpu_wdata,
   input logic [DATA_W-1:0] cpu_rdata,
   input logic              bus_cd_n_i,
   input logic              bus_io_n_i,
   input logic              bus_msg_n_i,
   input logic [DATA_W-1:0] db_n_o,
   input logic [DATA_W-1:0] db_oe_o,
   input logic              dbp_oe_o,
   input logic              atn_oe_o,
   input logic              ack_oe_o,
   input logic              sel_oe_o,
   input logic              bsy_oe_o,
   input logic              cd_oe_o,
   input logic              io_oe_o,
   input logic              msg_oe_o,
   input logic              req_oe_o
);

   localparam logic [ADDR_W-1:0] MODE_LOC = ADDR_W'(LOC_MODE);
   localparam logic [ADDR_W-1:0] TCMD_LOC = ADDR_W'(LOC_TCMD);

   logic mode_wr, tcmd_wr, mode_rd;
   logic tgt_s, od_s, xio_s, xcd_s, xmsg_s;
   logic any_tgt_oe, any_init_oe;

   assign mode_wr = cpu_sel && cpu_wr && (cpu_addr == MODE_LOC);
   assign tcmd_wr = cpu_sel && cpu_wr && (cpu_addr == TCMD_LOC);
   assign mode_rd = cpu_sel && !cpu_wr && (cpu_addr == MODE_LOC);
   assign any_tgt_oe  = cd_oe_o || io_oe_o || msg_oe_o || req_oe_o;
   assign any_init_oe = atn_oe_o || ack_oe_o;

   // shadow of the role, open-drain and expected-phase bits seen from the write port
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_s <= 1'b0; od_s <= 1'b0;
         xio_s <= 1'b0; xcd_s <= 1'b0; xmsg_s <= 1'b0;
      end else begin
         if (mode_wr) begin
            tgt_s <= cpu_wdata[MODE_TGT];
            od_s  <= cpu_wdata[MODE_OD];
         end
         if (tcmd_wr) begin
            xio_s  <= cpu_wdata[TCMD_IO];
            xcd_s  <= cpu_wdata[TCMD_CD];
            xmsg_s <= cpu_wdata[TCMD_MSG];
         end
      end
   end

   // R1
   always @(posedge clk) begin
      if (!rst_n) begin
         reset_quiet_chk: assert (db_oe_o == '0 && !dbp_oe_o && !any_init_oe &&
                                  !sel_oe_o && !bsy_oe_o && !any_tgt_oe)
            else $error("enable active during reset");
      end
   end

   // R2
   mode_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_rd && $past(mode_wr)) |-> (cpu_rdata == $past(cpu_wdata)));

   // R3
   init_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_init_oe |-> !tgt_s);

   // R4
   tgt_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_tgt_oe |-> tgt_s);

   // R3
   role_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(any_init_oe && any_tgt_oe));

   // R7
   init_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tgt_s && (db_oe_o != '0)) |->
         (bus_io_n_i && ((~bus_cd_n_i) == xcd_s) && ((~bus_io_n_i) == xio_s) &&
          ((~bus_msg_n_i) == xmsg_s)));

   // R6
   all_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !od_s |-> (((db_oe_o == '0) || (&db_oe_o)) && (dbp_oe_o == db_oe_o[0])));

   // R8
   od_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      od_s |-> ((db_oe_o & db_n_o) == '0));

endmodule

bind scsi_drive_ctl scsi_drive_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cpu_sel     (cpu_sel),
   .cpu_wr      (cpu_wr),
   .cpu_addr    (cpu_addr),
   .cpu_wdata   (cpu_wdata),
   .cpu_rdata   (cpu_rdata),
   .bus_cd_n_i  (bus_cd_n_i),
   .bus_io_n_i  (bus_io_n_i),
   .bus_msg_n_i (bus_msg_n_i),
   .db_n_o      (db_n_o),
   .db_oe_o     (db_oe_o),
   .dbp_oe_o    (dbp_oe_o),
   .atn_oe_o    (atn_oe_o),
   .ack_oe_o    (ack_oe_o),
   .sel_oe_o    (sel_oe_o),
   .bsy_oe_o    (bsy_oe_o),
   .cd_oe_o     (cd_oe_o),
   .io_oe_o     (io_oe_o),
   .msg_oe_o    (msg_oe_o),
   .req_oe_o    (req_oe_o)
);

// File: tb/test_scsi_drive_ctl.sv
module test_scsi_drive_ctl;
   import scsi_drive_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_sel = 1'b0, cpu_wr = 1'b0;
   logic [2:0] cpu_addr = '0;
   logic [7:0] cpu_wdata = '0;
   logic [7:0] cpu_rdata;
   logic [7:0] bus_db_n = 8'hFF;
   logic       bus_dbp_n = 1'b1, bus_cd_n = 1'b1, bus_io_n = 1'b1, bus_msg_n = 1'b1;
   logic       rx_strobe = 1'b0;
   logic [7:0] db_n_o, db_oe_o;
   logic       dbp_n_o, dbp_oe_o, atn_oe_o, ack_oe_o, sel_oe_o, bsy_oe_o;
   logic       cd_oe_o, io_oe_o, msg_oe_o, req_oe_o;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   scsi_drive_ctl i_scsi_drive_ctl (
      .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .bus_db_n_i(bus_db_n), .bus_dbp_n_i(bus_dbp_n), .bus_cd_n_i(bus_cd_n),
      .bus_io_n_i(bus_io_n), .bus_msg_n_i(bus_msg_n), .rx_strobe_i(rx_strobe),
      .db_n_o(db_n_o), .db_oe_o(db_oe_o), .dbp_n_o(dbp_n_o), .dbp_oe_o(dbp_oe_o),
      .atn_oe_o(atn_oe_o), .ack_oe_o(ack_oe_o), .sel_oe_o(sel_oe_o),
      .bsy_oe_o(bsy_oe_o), .cd_oe_o(cd_oe_o), .io_oe_o(io_oe_o),
      .msg_oe_o(msg_oe_o), .req_oe_o(req_oe_o));

   // {mode, icmd, tcmd, odata, {cd_n,io_n,msg_n}, expected
   //  {data,parity,atn,ack,sel,bsy,cd,io,msg,req}}
   localparam int NVEC = 9;
   localparam logic [44:0] VEC [NVEC] = '{
      {8'h00, 8'h13, 8'h0F, 8'h5A, 3'b111, 10'b0011000000}, // R3 R7 expected I/O true, bus false
      {8'h00, 8'h13, 8'h00, 8'h5A, 3'b111, 10'b1111000000}, // R7 phase match
      {8'h00, 8'h01, 8'h02, 8'h3C, 3'b011, 10'b1100000000}, // R7 C/D expected and seen
      {8'h00, 8'h01, 8'h02, 8'h3C, 3'b111, 10'b0000000000}, // R7 C/D expected, not seen
      {8'h00, 8'h01, 8'h01, 8'h3C, 3'b101, 10'b0000000000}, // R7 bus I/O true blocks
      {8'h40, 8'h1F, 8'h0F, 8'hA5, 3'b000, 10'b1100111111}, // R4 R6 target, all bits
      {8'h40, 8'h0C, 8'h0A, 8'h00, 3'b111, 10'b0000111001}, // R4 R5 target subset
      {8'h00, 8'h06, 8'h00, 8'h00, 3'b111, 10'b0010100000}, // R5 SEL with ATN
      {8'h00, 8'h08, 8'h0F, 8'h00, 3'b111, 10'b0000010000}  // R4 tcmd ignored as initiator
   };

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      cpu_sel = 1'b0; cpu_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      cpu_sel = 1'b1; cpu_wr = 1'b0; cpu_addr = a;
      #1 d = cpu_rdata;
      @(negedge clk);
      cpu_sel = 1'b0;
   endtask

   task automatic rx_byte(input logic [7:0] d, input logic p);
      @(negedge clk);
      bus_db_n = ~d; bus_dbp_n = ~p; rx_strobe = 1'b1;
      @(negedge clk);
      rx_strobe = 1'b0; bus_db_n = 8'hFF; bus_dbp_n = 1'b1;
   endtask

   function automatic logic [16:0] all_oe();
      return {db_oe_o, dbp_oe_o, atn_oe_o, ack_oe_o, sel_oe_o, bsy_oe_o,
              cd_oe_o, io_oe_o, msg_oe_o, req_oe_o};
   endfunction

   function automatic logic odd_bit(input logic [7:0] d);
      int ones = 0;
      for (int k = 0; k < 8; k++) ones += int'(d[k]);
      return (ones % 2 == 0);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      finish_run();
   end

   initial begin
      logic [7:0] rv;
      logic [44:0] e;

      // R1 reset state
      repeat (3) @(negedge clk);
      chk("R1 enables in reset", 32'(all_oe()), 32'h0);
      chk("R1 rdata idle in reset", 32'(cpu_rdata), 32'h0);
      rst_n = 1'b1;
      for (int a = 0; a < 5; a++) begin
         rd(3'(a), rv);
         chk("R1 location after reset", 32'(rv), 32'h0);
      end
      chk("R1 enables after reset", 32'(all_oe()), 32'h0);

      // drive table: R3 R4 R5 R6 R7
      for (int v = 0; v < NVEC; v++) begin
         e = VEC[v];
         wr(LOC_MODE, e[44:37]);
         wr(LOC_ICMD, e[36:29]);
         wr(LOC_TCMD, e[28:21]);
         wr(LOC_ODATA, e[20:13]);
         {bus_cd_n, bus_io_n, bus_msg_n} = e[12:10];
         #1;
         chk($sformatf("R3/R4/R5 control enables vector %0d", v),
             32'({atn_oe_o, ack_oe_o, sel_oe_o, bsy_oe_o, cd_oe_o, io_oe_o, msg_oe_o, req_oe_o}),
             32'(e[7:0]));
         chk($sformatf("R6/R7 data enables vector %0d", v),
             32'({db_oe_o, dbp_oe_o}), 32'({{8{e[9]}}, e[8]}));
         if (e[9])
            chk($sformatf("R6 data value vector %0d", v),
                32'({db_n_o, dbp_n_o}), 32'({~e[20:13], ~odd_bit(e[20:13])}));
      end
      {bus_cd_n, bus_io_n, bus_msg_n} = 3'b111;

      // R2 readback independent of bus activity
      wr(LOC_MODE, 8'hA5);
      wr(LOC_ICMD, 8'h3C);
      wr(LOC_TCMD, 8'hF5);
      wr(LOC_ODATA, 8'h96);
      bus_db_n = 8'h00; bus_io_n = 1'b0; bus_cd_n = 1'b0;
      rd(LOC_MODE, rv);  chk("R2 mode readback", 32'(rv), 32'hA5);
      rd(LOC_ICMD, rv);  chk("R2 initiator command readback", 32'(rv), 32'h3C);
      rd(LOC_TCMD, rv);  chk("R2 target command readback", 32'(rv), 32'hF5);
      rd(LOC_ODATA, rv); chk("R2 data readback", 32'(rv), 32'h96);
      bus_db_n = 8'hFF; bus_io_n = 1'b1; bus_cd_n = 1'b1;

      // R6 parity generation
      wr(LOC_MODE, 8'h40);
      wr(LOC_ICMD, 8'h01);
      wr(LOC_ODATA, 8'h00);
      #1 chk("R6 parity pin for zero ones", 32'({db_n_o, dbp_n_o}), 32'({8'hFF, 1'b0}));
      wr(LOC_ODATA, 8'h01);
      #1 chk("R6 parity pin for one one", 32'({db_n_o, dbp_n_o}), 32'({8'hFE, 1'b1}));

      // R7 phase change removes drive in the same cycle
      wr(LOC_MODE, 8'h00);
      wr(LOC_TCMD, 8'h00);
      #1 chk("R7 drive with matching phase", 32'(db_oe_o), 32'hFF);
      #3 bus_msg_n = 1'b0;
      #1 chk("R7 drive dropped within cycle", 32'({db_oe_o, dbp_oe_o}), 32'h0);
      bus_msg_n = 1'b1;

      // R8 open drain
      wr(LOC_MODE, 8'hC0);
      wr(LOC_ODATA, 8'h5A);
      #1 chk("R8 open drain lines", 32'({db_oe_o, dbp_oe_o, dbp_n_o}), 32'({8'h5A, 1'b1, 1'b0}));
      wr(LOC_ODATA, 8'h01);
      #1 chk("R8 open drain parity released", 32'({db_oe_o, dbp_oe_o}), 32'({8'h01, 1'b0}));
      wr(LOC_MODE, 8'h40);
      #1 chk("R8 open drain cleared", 32'({db_oe_o, dbp_oe_o}), 32'({8'hFF, 1'b1}));

      // R9 parity check
      wr(LOC_ICMD, 8'h00);
      wr(LOC_MODE, 8'h00);
      rx_byte(8'h03, 1'b0);
      rd(LOC_STAT, rv); chk("R9 error ignored when checking off", 32'(rv), 32'h0);
      wr(LOC_MODE, 8'h20);
      rx_byte(8'h03, 1'b1);
      rd(LOC_STAT, rv); chk("R9 good parity no error", 32'(rv), 32'h0);
      rx_byte(8'h03, 1'b0);
      repeat (4) @(negedge clk);
      rd(LOC_STAT, rv); chk("R9 R10 bad parity latched and held", 32'(rv), 32'h1);
      rd(LOC_STAT, rv); chk("R10 cleared by status read", 32'(rv), 32'h0);
      rx_byte(8'h00, 1'b0);
      rd(LOC_STAT, rv); chk("R9 all-zero word is an error", 32'(rv), 32'h1);

      // R10 error and clearing read in one cycle
      @(negedge clk);
      bus_db_n = ~8'h03; bus_dbp_n = 1'b1; rx_strobe = 1'b1;
      cpu_sel = 1'b1; cpu_wr = 1'b0; cpu_addr = LOC_STAT;
      #1 chk("R10 read during new error", 32'(cpu_rdata), 32'h0);
      @(negedge clk);
      rx_strobe = 1'b0; cpu_sel = 1'b0; bus_db_n = 8'hFF;
      rd(LOC_STAT, rv); chk("R10 new error outranks clear", 32'(rv), 32'h1);

      finish_run();
   end

endmodule